// File: doc/BRIEF.md
# Power-Management Wake Event Status and Routing

This block holds one sticky event flag that records a power-management request raised by an on-chip device, together with a matching enable flag. Software sees both flags through a small register port. One register holds the event flag and clears it with write-1-to-clear. The other register holds the enable flag as an ordinary read/write bit.

While the flag and its enable are both set, the block reports the event. What it does depends on the system power state presented at its input. In the working state it raises a level toward the OS (SCI), or toward firmware (SMI) when the SCI-enable input is low. In the sleeping states it does the same and also emits a one-cycle wake request at the moment the flag sets. The soft-off state counts as a sleeping state when it was entered by a software sleep request. When soft-off was forced by holding the power button, the event is reported nowhere.

Top module: `pme_wake_ctrl`

## Requirements
- R1: After reset the event flag and the enable flag are 0, and sci_o, smi_o and wake_o are low.
- R2: A cycle with pme_req high sets the event flag on the next clock edge. The flag reads back as bit 13 of the register at offset 0x28, and the flag stays set after pme_req drops.
- R3: A write to offset 0x28 with bit 13 set clears the event flag. A write there with bit 13 clear, or a write to any offset other than 0x28, leaves the flag unchanged.
- R4: When pme_req is high in the same cycle as a clearing write, the event flag ends up set.
- R5: The enable flag is bit 13 of the register at offset 0x2C and is written directly. All other bits of both registers, and every other offset, read as 0.
- R6: sys_state encodes S0..S5 as 0..5. In S0, with the flag, the enable and sci_en all high, sci_o is high. wake_o never pulses for a flag that sets in S0.
- R7: With sci_en low, the condition that would raise sci_o raises smi_o instead. sci_o and smi_o are never high together.
- R8: In S1..S4, or in S5 with pwrbtn_ovr low, the flag setting while the enable is high gives a one-cycle wake_o pulse in the cycle after the setting edge. The flag also raises sci_o or smi_o as in R6 and R7.
- R9: In S5 with pwrbtn_ovr high, sci_o, smi_o and wake_o all stay low.
- R10: With the enable flag clear, the event flag raises none of sci_o, smi_o or wake_o.
- R11: sys_state values 6 and 7 route nothing.
- R12: sci_o and smi_o are levels. They drop in the cycle after the event flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pme_req | input | 1 | Power-management event request from internal devices |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, used for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sys_state | input | 3 | Current power state, 0..5 = S0..S5 |
| pwrbtn_ovr | input | 1 | S5 was entered through power-button override |
| sci_en | input | 1 | Route events to SCI (1) or SMI (0) |
| sci_o | output | 1 | SCI request level |
| smi_o | output | 1 | SMI request level |
| wake_o | output | 1 | One-cycle wake request |

## Verification
Directed sequences first walk each power state with the enable set. They separate the working state, which gives a level but no wake, from the sleeping states, which give both, and both from forced-off, which gives neither. Toggling sci_en on a flag that is already set shows that sci_o and smi_o are steered by the input, not latched. A request that lands on a clearing write shows which of the two wins. A constrained random run then mixes requests, clears, enable writes, stray offsets and state changes. A reference model in the bench follows every read-back and output level cycle by cycle.

// File: rtl/pme_pkg.sv
// Package: shared types and the power-state classifier for the wake event block.
// Assumes a 3-bit state code where 0..5 name S0..S5 and 6..7 are unused.
package pme_pkg;

    typedef enum logic [2:0] {
        PS_S0 = 3'd0,
        PS_S1 = 3'd1,
        PS_S2 = 3'd2,
        PS_S3 = 3'd3,
        PS_S4 = 3'd4,
        PS_S5 = 3'd5
    } pstate_e;

    typedef struct packed {
        logic report;   // event may be reported as SCI/SMI
        logic sleeping; // event may also request a wake
    } route_t;

    // Classify the power state into reporting and wake eligibility.
    function automatic route_t classify(input logic [2:0] st, input logic pbo);
        route_t r;
        r.report   = 1'b0;
        r.sleeping = 1'b0;
        case (st)
            PS_S0: r.report = 1'b1;
            PS_S1, PS_S2, PS_S3, PS_S4: begin
                r.report   = 1'b1;
                r.sleeping = 1'b1;
            end
            PS_S5: begin
                r.report   = !pbo;
                r.sleeping = !pbo;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pme_reg_if.sv
// Module: register port decode. Turns writes into a flag-clear strobe and an
// enable write, and muxes the read-back. Assumes single-cycle writes and
// combinational reads addressed by the same offset bus.
module pme_reg_if #(
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 32,
    parameter logic [7:0]  STS_OFS = 8'h28,
    parameter logic [7:0]  EN_OFS  = 8'h2C,
    parameter int          EVT_BIT = 13
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              sts_q,
    input  logic              en_q,
    output logic              sts_clr,
    output logic              en_we,
    output logic              en_wd,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFS);
    localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(EN_OFS);

    logic hit_sts;
    logic hit_en;

    // Address decode for the two registers.
    always_comb begin
        hit_sts = (reg_addr == STS_A);
        hit_en  = (reg_addr == EN_A);
    end

    // Write strobes derived from the decode and the event bit of the data.
    always_comb begin
        sts_clr = reg_wr && hit_sts && reg_wdata[EVT_BIT];
        en_we   = reg_wr && hit_en;
        en_wd   = reg_wdata[EVT_BIT];
    end

    // Read-back mux; unused bits and offsets read zero.
    always_comb begin
        reg_rdata = '0;
        if (hit_sts)     reg_rdata[EVT_BIT] = sts_q;
        else if (hit_en) reg_rdata[EVT_BIT] = en_q;
    end

endmodule

// File: rtl/pme_flags.sv
// Module: the sticky event flag and its enable flag. A request that coincides
// with a clear keeps the flag set. Also flags the cycle in which the event
// flag is about to go from 0 to 1.
module pme_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic pme_req,
    input  logic sts_clr,
    input  logic en_we,
    input  logic en_wd,
    output logic sts_q,
    output logic en_q,
    output logic sts_rise
);

    // Sticky event flag: set wins over write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       sts_q <= 1'b0;
        else if (pme_req) sts_q <= 1'b1;
        else if (sts_clr) sts_q <= 1'b0;
    end

    // Enable flag: plain read/write bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (en_we) en_q <= en_wd;
    end

    // Flag is clear now and will be set after this edge.
    always_comb sts_rise = pme_req && !sts_q;

endmodule

// File: rtl/pme_router.sv
// Module: steers a pending enabled event to SCI or SMI according to the power
// state and sci_en, and produces a registered one-cycle wake pulse when the
// flag sets in an eligible sleep state. Assumes state inputs are synchronous.
module pme_router
    import pme_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sts_q,
    input  logic       en_q,
    input  logic       sts_rise,
    input  logic [2:0] sys_state,
    input  logic       pwrbtn_ovr,
    input  logic       sci_en,
    output logic       sci_o,
    output logic       smi_o,
    output logic       wake_o
);

    route_t rt;
    logic   pending;

    // Classify the present state and form the pending condition.
    always_comb begin
        rt      = classify(sys_state, pwrbtn_ovr);
        pending = sts_q && en_q && rt.report;
    end

    // Level outputs: exactly one path depending on sci_en.
    always_comb begin
        sci_o = pending && sci_en;
        smi_o = pending && !sci_en;
    end

    // Wake pulse registered on the edge that sets the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_o <= 1'b0;
        else        wake_o <= sts_rise && en_q && rt.sleeping;
    end

endmodule

// File: rtl/pme_wake_ctrl.sv
// Module: top of the wake event status and routing block. Connects the register
// port, the flags and the router. All outputs except reg_rdata, sci_o and
// smi_o are registered; those three follow the inputs combinationally.
module pme_wake_ctrl #(
    parameter int         ADDR_W  = 8,
    parameter int         DATA_W  = 32,
    parameter logic [7:0] STS_OFS = 8'h28,
    parameter logic [7:0] EN_OFS  = 8'h2C,
    parameter int         EVT_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pme_req,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [2:0]        sys_state,
    input  logic              pwrbtn_ovr,
    input  logic              sci_en,
    output logic              sci_o,
    output logic              smi_o,
    output logic              wake_o
);

    logic sts_q;
    logic en_q;
    logic sts_clr;
    logic en_we;
    logic en_wd;
    logic sts_rise;

    pme_reg_if #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STS_OFS(STS_OFS),
        .EN_OFS (EN_OFS),
        .EVT_BIT(EVT_BIT)
    ) u_regs (
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .sts_q    (sts_q),
        .en_q     (en_q),
        .sts_clr  (sts_clr),
        .en_we    (en_we),
        .en_wd    (en_wd),
        .reg_rdata(reg_rdata)
    );

    pme_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .pme_req (pme_req),
        .sts_clr (sts_clr),
        .en_we   (en_we),
        .en_wd   (en_wd),
        .sts_q   (sts_q),
        .en_q    (en_q),
        .sts_rise(sts_rise)
    );

    pme_router u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .sts_q     (sts_q),
        .en_q      (en_q),
        .sts_rise  (sts_rise),
        .sys_state (sys_state),
        .pwrbtn_ovr(pwrbtn_ovr),
        .sci_en    (sci_en),
        .sci_o     (sci_o),
        .smi_o     (smi_o),
        .wake_o    (wake_o)
    );

endmodule

// File: rtl/pme_wake_chk.sv
// Module: assertion checker bound to pme_wake_ctrl. Observes ports and the two
// internal flags; drives nothing.
module pme_wake_chk #(
    parameter int         ADDR_W  = 8,
    parameter int         DATA_W  = 32,
    parameter logic [7:0] STS_OFS = 8'h28,
    parameter int         EVT_BIT = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pme_req,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [2:0]        sys_state,
    input logic              pwrbtn_ovr,
    input logic              sci_o,
    input logic              smi_o,
    input logic              wake_o,
    input logic              sts_q,
    input logic              en_q
);

    logic clr_wr;
    always_comb clr_wr = reg_wr && (reg_addr == ADDR_W'(STS_OFS)) && reg_wdata[EVT_BIT];

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pme_req |=> sts_q);

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !pme_req) |=> !sts_q);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && !pme_req) |=> $stable(sts_q));

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sci_o && smi_o));

    p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    p_no_wake_s0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_state == 3'd0) |=> !wake_o);

    p_pbo_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_state == 3'd5 && pwrbtn_ovr) |-> (!sci_o && !smi_o));

    p_pbo_nowake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_state == 3'd5 && pwrbtn_ovr) |=> !wake_o);

    p_need_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!sci_o && !smi_o));

    p_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_q |-> (!sci_o && !smi_o));

endmodule

bind pme_wake_ctrl pme_wake_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STS_OFS(STS_OFS),
    .EVT_BIT(EVT_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pme_req   (pme_req),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sys_state (sys_state),
    .pwrbtn_ovr(pwrbtn_ovr),
    .sci_o     (sci_o),
    .smi_o     (smi_o),
    .wake_o    (wake_o),
    .sts_q     (sts_q),
    .en_q      (en_q)
);

// File: tb/tb_pme_wake_ctrl.sv
// Bench: directed corners followed by seeded random traffic, compared against
// a cycle model written from the requirements.
module tb_pme_wake_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pme_req = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  sys_state = 3'd0;
    logic        pwrbtn_ovr = 1'b0;
    logic        sci_en = 1'b1;
    logic        sci_o;
    logic        smi_o;
    logic        wake_o;

    int checks = 0;
    int errors = 0;

    logic m_sts = 1'b0;
    logic m_en = 1'b0;
    logic m_wake = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pme_wake_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pme_req   (pme_req),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sys_state (sys_state),
        .pwrbtn_ovr(pwrbtn_ovr),
        .sci_en    (sci_en),
        .sci_o     (sci_o),
        .smi_o     (smi_o),
        .wake_o    (wake_o)
    );

    // States in which the event is reported at all.
    function automatic logic f_report(input logic [2:0] st, input logic pbo);
        return (st <= 3'd4) || (st == 3'd5 && !pbo);
    endfunction

    // States in which the event also wakes the system.
    function automatic logic f_sleep(input logic [2:0] st, input logic pbo);
        return f_report(st, pbo) && (st != 3'd0);
    endfunction

    function automatic logic [31:0] f_rdata(input logic [7:0] a, input logic s, input logic e);
        logic [31:0] v = '0;
        if (a == 8'h28)      v[13] = s;
        else if (a == 8'h2C) v[13] = e;
        return v;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock cycle: drive, check outputs against the model, advance the model.
    task automatic cyc(input string req, input logic pme, input logic wr, input logic [7:0] a,
                       input logic [31:0] wd, input logic [2:0] st, input logic pbo, input logic se);
        logic rep;
        logic clr;
        logic nsts;
        @(negedge clk);
        pme_req = pme; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        sys_state = st; pwrbtn_ovr = pbo; sci_en = se;
        #1;
        rep = f_report(st, pbo);
        check(req, "wake_o", 32'(wake_o), 32'(m_wake));
        check(req, "sci_o", 32'(sci_o), 32'(m_sts && m_en && rep && se));
        check(req, "smi_o", 32'(smi_o), 32'(m_sts && m_en && rep && !se));
        check(req, "reg_rdata", reg_rdata, f_rdata(a, m_sts, m_en));
        clr    = wr && (a == 8'h28) && wd[13];
        nsts   = pme || (m_sts && !clr);
        m_wake = !m_sts && nsts && m_en && f_sleep(st, pbo);
        if (wr && a == 8'h2C) m_en = wd[13];
        m_sts  = nsts;
    endtask

    localparam logic [31:0] B13 = 32'h0000_2000;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1", "sci_o in reset", 32'(sci_o), 32'd0);
        check("R1", "wake_o in reset", 32'(wake_o), 32'd0);
        rst_n = 1'b1;
        // R1: reset values read back
        cyc("R1", 0, 0, 8'h28, 0, 0, 0, 1);
        cyc("R1", 0, 0, 8'h2C, 0, 0, 0, 1);
        // R5: enable write, other bits read zero
        cyc("R5", 0, 1, 8'h2C, 32'hFFFF_DFFF, 0, 0, 1);
        cyc("R5", 0, 0, 8'h2C, 0, 0, 0, 1);
        cyc("R5", 0, 1, 8'h2C, B13, 0, 0, 1);
        cyc("R5", 0, 0, 8'h2C, 0, 0, 0, 1);
        // R2, R6: set in S0 gives SCI and no wake
        cyc("R2", 1, 0, 8'h28, 0, 0, 0, 1);
        cyc("R6", 0, 0, 8'h28, 0, 0, 0, 1);
        cyc("R6", 0, 0, 8'h40, 0, 0, 0, 1);
        // R7: sci_en low steers to SMI
        cyc("R7", 0, 0, 8'h28, 0, 0, 0, 0);
        cyc("R7", 0, 0, 8'h28, 0, 0, 0, 1);
        // R3: non-clearing writes leave flag
        cyc("R3", 0, 1, 8'h28, ~B13, 0, 0, 1);
        cyc("R3", 0, 1, 8'h2A, B13, 0, 0, 1);
        cyc("R3", 0, 0, 8'h28, 0, 0, 0, 1);
        // R4: request on the clear cycle wins
        cyc("R4", 1, 1, 8'h28, B13, 0, 0, 1);
        cyc("R4", 0, 0, 8'h28, 0, 0, 0, 1);
        // R12, R3: clear drops the level
        cyc("R12", 0, 1, 8'h28, B13, 0, 0, 1);
        cyc("R12", 0, 0, 8'h28, 0, 0, 0, 1);
        // R8: wake in S3 with SMI
        cyc("R8", 1, 0, 8'h28, 0, 3, 0, 0);
        cyc("R8", 0, 0, 8'h28, 0, 3, 0, 0);
        cyc("R8", 0, 0, 8'h28, 0, 3, 0, 0);
        cyc("R8", 0, 1, 8'h28, B13, 3, 0, 1);
        // R8: S5 by sleep request wakes
        cyc("R8", 1, 0, 8'h28, 0, 5, 0, 1);
        cyc("R8", 0, 0, 8'h28, 0, 5, 0, 1);
        cyc("R8", 0, 1, 8'h28, B13, 5, 0, 1);
        // R9: S5 by power-button override is silent
        cyc("R9", 1, 0, 8'h28, 0, 5, 1, 1);
        cyc("R9", 0, 0, 8'h28, 0, 5, 1, 0);
        cyc("R9", 0, 1, 8'h28, B13, 5, 1, 1);
        // R11: unused state codes
        cyc("R11", 1, 0, 8'h28, 0, 6, 0, 1);
        cyc("R11", 0, 0, 8'h28, 0, 7, 0, 0);
        cyc("R11", 0, 1, 8'h28, B13, 7, 0, 1);
        // R10: enable clear blocks everything
        cyc("R10", 0, 1, 8'h2C, 0, 2, 0, 1);
        cyc("R10", 1, 0, 8'h28, 0, 2, 0, 1);
        cyc("R10", 0, 0, 8'h28, 0, 2, 0, 1);
        cyc("R10", 0, 1, 8'h28, B13, 2, 0, 1);
        // Random traffic against the model
        void'($urandom(32'd2024));
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] a;
            logic [31:0] wd;
            logic [2:0] st;
            case ($urandom % 4)
                0: a = 8'h28;
                1: a = 8'h2C;
                2: a = 8'h2A;
                default: a = 8'h30;
            endcase
            wd = $urandom;
            wd[13] = ($urandom % 3) != 0;
            st = 3'($urandom % 8);
            cyc("R8", ($urandom % 5) == 0, ($urandom % 3) == 0, a, wd, st,
                ($urandom % 2) == 0, ($urandom % 4) != 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule